// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block is the digital control for a converter that serves up to eight analog inputs. A channel mask picks which inputs take part. While the run bit is set, the sequencer starts conversions one at a time through a start/done handshake with an abstract converter core. It walks the selected channels from the lowest index upward and wraps back to the lowest. In free-running mode it launches the next conversion as soon as the previous one returns. In triggered mode each trigger pulse launches exactly one conversion.

Every result lands in its own per-channel register, together with a completion flag and an overrun flag. Reading a channel through a one-cycle read strobe returns its result and flags and then clears the flags. Per-channel interrupt enables gate the completion flags onto one interrupt line. Clearing the run bit never cuts short a conversion that is already in flight. An optional single-pass setting drops the run bit by itself once the highest selected channel has completed, so a full pass never overwrites an unread result.

Top module: `adc_scan_seq`

## Requirements
- R1: After `run_set`, conversions start at the lowest channel set in `cfg_mask` and go up in channel order. `conv_chan` carries the binary channel index, valid while `conv_start` is high.
- R2: In free-running mode (`cfg_trig_mode`=0) with `cfg_single`=0, the scan wraps from the highest selected channel back to the lowest and keeps going while `run` is 1.
- R3: `ch_done` and `ch_overrun` are 0 after reset. A completion sets bit c of `ch_done` for channel c. A read strobe on channel c returns the stored result, done flag and overrun flag on `rd_data`, `rd_done` and `rd_ovr` one cycle later, and clears both flags of c in the same edge.
- R4: A completion for channel c while `ch_done[c]` is still 1 sets `ch_overrun[c]`.
- R5: `irq` is 1 exactly when some channel c has both `ch_done[c]` and `cfg_irq_en[c]` set, one cycle after those flags change. Done flags of channels whose enable is 0 have no effect on `irq`.
- R6: `run_clr` clears `run` in the next edge. A conversion already in flight keeps `busy` high, completes and writes its result, and no further conversion starts.
- R7: In triggered mode (`cfg_trig_mode`=1), each `trig` pulse while `run` is 1 and `busy` is 0 starts exactly one conversion of the next selected channel, wrapping as in R2. Without a trigger no conversion starts, and a trigger while `busy` is 1 is ignored.
- R8: With `cfg_single`=1, `run` drops in the edge that records the completion of the highest selected channel. Each selected channel is converted once, and none shows overrun.
- R9: While `cfg_mask` is 0, `run_set` leaves `run` at 0 and no conversion starts, whether or not a trigger arrives.
- R10: `glb_done` is set by any completion, and `last_chan` then names that channel. `glb_done` clears when that channel is read. `busy` is 1 from the start of a conversion until its completion is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mask | input | 8 | Channel select mask |
| cfg_trig_mode | input | 1 | 0 free-running, 1 one conversion per trigger |
| cfg_single | input | 1 | Stop after one full pass |
| cfg_irq_en | input | 8 | Per-channel interrupt enable |
| run_set | input | 1 | Pulse: set the run bit |
| run_clr | input | 1 | Pulse: clear the run bit (wins over set) |
| trig | input | 1 | Trigger pulse for triggered mode |
| conv_start | output | 1 | One-cycle start to the converter core |
| conv_chan | output | 3 | Channel being converted |
| conv_done | input | 1 | One-cycle completion from the core |
| conv_data | input | 12 | Result, valid with conv_done |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_chan | input | 3 | Channel to read |
| rd_data | output | 12 | Result read back |
| rd_done | output | 1 | Done flag read back |
| rd_ovr | output | 1 | Overrun flag read back |
| ch_done | output | 8 | Per-channel done flags |
| ch_overrun | output | 8 | Per-channel overrun flags |
| glb_done | output | 1 | Any result since the last one was read |
| last_chan | output | 3 | Most recently completed channel |
| busy | output | 1 | Conversion in flight |
| run | output | 1 | Run bit |
| irq | output | 1 | Interrupt request |

## Verification
A start follows one edge after the cycle that allows it: run set and idle, or a trigger captured. The bench's core model returns the completion a fixed four cycles after it sees the start. Flags, `glb_done`, `busy` and `run` change in the edge that captures the completion, and read data appears one edge after the strobe. `irq` lags the flags by one more edge. The bench drives every stimulus one nanosecond after a falling edge and samples at the falling edge that follows the edge in question. Where the moment of completion is fixed by the core model rather than the block, it waits on `busy` with a bounded loop and then checks the settled state.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic {
    SCAN_FREE = 1'b0,
    SCAN_TRIG = 1'b1
  } scan_mode_e;
endpackage

// File: rtl/adc_chan_pick.sv
// Finds the next selected channel at or above a pointer, wrapping to the
// lowest selected one, and reports the highest selected channel.
module adc_chan_pick #(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] mask,
  input  logic [CW-1:0]  ptr,
  output logic [CW-1:0]  nxt_chan,
  output logic [CW-1:0]  top_chan,
  output logic           any_en
);
  logic [CW-1:0] up_sel, lo_sel;
  logic          up_vld;

  always_comb begin
    up_sel   = '0;
    lo_sel   = '0;
    up_vld   = 1'b0;
    top_chan = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i] && (i >= int'(ptr))) begin
        up_sel = CW'(i);
        up_vld = 1'b1;
      end
      if (mask[i]) lo_sel = CW'(i);
    end
    for (int i = 0; i < NCH; i++) begin
      if (mask[i]) top_chan = CW'(i);
    end
  end

  assign nxt_chan = up_vld ? up_sel : lo_sel;
  assign any_en   = |mask;
endmodule

// File: rtl/adc_seq_ctrl.sv
// Run bit, scan pointer and the start/done handshake with the core.
module adc_seq_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] mask,
  input  logic           trig_mode,
  input  logic           single,
  input  logic           run_set,
  input  logic           run_clr,
  input  logic           trig,
  input  logic           conv_done,
  input  logic [CW-1:0]  nxt_chan,
  input  logic [CW-1:0]  top_chan,
  input  logic           any_en,
  output logic [CW-1:0]  ptr,
  output logic           conv_start,
  output logic [CW-1:0]  conv_chan,
  output logic           busy,
  output logic           run,
  output logic           wr_en
);
  scan_mode_e mode;
  logic       go;
  logic       fin;
  logic [CW-1:0] ptr_wrap;

  assign mode     = scan_mode_e'(trig_mode);
  assign fin      = busy && conv_done;
  assign go       = run && !busy && any_en && ((mode == SCAN_FREE) || trig);
  assign ptr_wrap = (conv_chan == CW'(NCH - 1)) ? '0 : conv_chan + 1'b1;
  assign wr_en    = fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      run        <= 1'b0;
      busy       <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      ptr        <= '0;
    end else begin
      conv_start <= 1'b0;
      if (run_clr) begin
        run <= 1'b0;
      end else if (run_set && any_en) begin
        run <= 1'b1;
        ptr <= '0;
      end
      if (fin) begin
        busy <= 1'b0;
        ptr  <= ptr_wrap;
        if (single && (conv_chan == top_chan)) run <= 1'b0;
      end else if (go) begin
        busy       <= 1'b1;
        conv_start <= 1'b1;
        conv_chan  <= nxt_chan;
      end
    end
  end

  // R6: an in-flight conversion is never dropped before its completion
  a_r6_inflight_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !conv_done) |=> busy);
  // R7: no start is issued while a conversion is in flight
  a_r7_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> !$past(busy));
  // R7: in triggered mode every start follows a trigger
  a_r7_trig_needed: assert property (@(posedge clk) disable iff (rst)
    (conv_start && $past(trig_mode)) |-> $past(trig));
  // R9: an empty mask never yields a start
  a_r9_empty_mask: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> ($past(mask) != '0));
  // R8: completing the top channel in single-pass mode drops run
  a_r8_single_stop: assert property (@(posedge clk) disable iff (rst)
    (fin && single && (conv_chan == top_chan)) |=> !run);
endmodule

// File: rtl/adc_result_bank.sv
// Per-channel result storage with completion and overrun flags.
module adc_result_bank #(
  parameter int NCH = 8,
  parameter int DW  = 12,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [CW-1:0]  wr_chan,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_stb,
  input  logic [CW-1:0]  rd_chan,
  output logic [DW-1:0]  rd_data,
  output logic           rd_done,
  output logic           rd_ovr,
  output logic [NCH-1:0] done,
  output logic [NCH-1:0] ovr,
  output logic           glb_done,
  output logic [CW-1:0]  last_chan
);
  logic [DW-1:0] mem [NCH];

  // Plain RAM: write port from the core, registered read port.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_chan] <= wr_data;
    if (rd_stb) rd_data <= mem[rd_chan];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_flag
    logic wr_hit, rd_hit;
    assign wr_hit = wr_en && (wr_chan == CW'(c));
    assign rd_hit = rd_stb && (rd_chan == CW'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        done[c] <= 1'b0;
        ovr[c]  <= 1'b0;
      end else if (wr_hit) begin
        done[c] <= 1'b1;
        ovr[c]  <= !rd_hit && (done[c] || ovr[c]);
      end else if (rd_hit) begin
        done[c] <= 1'b0;
        ovr[c]  <= 1'b0;
      end
    end

    // R4: an overrun flag never stands without its done flag
    a_r4_ovr_has_done: assert property (@(posedge clk) disable iff (rst)
      ovr[c] |-> done[c]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_done   <= 1'b0;
      rd_ovr    <= 1'b0;
      glb_done  <= 1'b0;
      last_chan <= '0;
    end else begin
      if (rd_stb) begin
        rd_done <= done[rd_chan];
        rd_ovr  <= ovr[rd_chan];
      end
      if (wr_en) begin
        glb_done  <= 1'b1;
        last_chan <= wr_chan;
      end else if (rd_stb && (rd_chan == last_chan)) begin
        glb_done <= 1'b0;
      end
    end
  end

  // R10: the global flag always points at a channel still marked done
  a_r10_glb_tracks: assert property (@(posedge clk) disable iff (rst)
    glb_done |-> done[last_chan]);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH = 8,
  parameter int DW  = 12,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] cfg_mask,
  input  logic           cfg_trig_mode,
  input  logic           cfg_single,
  input  logic [NCH-1:0] cfg_irq_en,
  input  logic           run_set,
  input  logic           run_clr,
  input  logic           trig,
  output logic           conv_start,
  output logic [CW-1:0]  conv_chan,
  input  logic           conv_done,
  input  logic [DW-1:0]  conv_data,
  input  logic           rd_stb,
  input  logic [CW-1:0]  rd_chan,
  output logic [DW-1:0]  rd_data,
  output logic           rd_done,
  output logic           rd_ovr,
  output logic [NCH-1:0] ch_done,
  output logic [NCH-1:0] ch_overrun,
  output logic           glb_done,
  output logic [CW-1:0]  last_chan,
  output logic           busy,
  output logic           run,
  output logic           irq
);
  logic [CW-1:0] ptr, nxt_chan, top_chan;
  logic          any_en, wr_en;

  adc_chan_pick #(.NCH(NCH)) u_pick (
    .mask     (cfg_mask),
    .ptr      (ptr),
    .nxt_chan (nxt_chan),
    .top_chan (top_chan),
    .any_en   (any_en)
  );

  adc_seq_ctrl #(.NCH(NCH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .mask       (cfg_mask),
    .trig_mode  (cfg_trig_mode),
    .single     (cfg_single),
    .run_set    (run_set),
    .run_clr    (run_clr),
    .trig       (trig),
    .conv_done  (conv_done),
    .nxt_chan   (nxt_chan),
    .top_chan   (top_chan),
    .any_en     (any_en),
    .ptr        (ptr),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .busy       (busy),
    .run        (run),
    .wr_en      (wr_en)
  );

  adc_result_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_chan   (conv_chan),
    .wr_data   (conv_data),
    .rd_stb    (rd_stb),
    .rd_chan   (rd_chan),
    .rd_data   (rd_data),
    .rd_done   (rd_done),
    .rd_ovr    (rd_ovr),
    .done      (ch_done),
    .ovr       (ch_overrun),
    .glb_done  (glb_done),
    .last_chan (last_chan)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(ch_done & cfg_irq_en);
  end

  // R5: a rising interrupt always has a done flag behind it
  a_r5_irq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(ch_done) != '0));
endmodule

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/100ps
module sim_adc_scan_seq;
  localparam int NCH = 8;
  localparam int DW  = 12;
  localparam int CW  = 3;
  localparam int LAT = 4;
  // {mask, expected conversions in one single pass}
  localparam logic [11:0] VEC [4] = '{
    {8'h7F, 4'd7}, {8'h81, 4'd2}, {8'h24, 4'd2}, {8'hFF, 4'd8}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] cfg_mask = '0, cfg_irq_en = '0;
  logic cfg_trig_mode = 1'b0, cfg_single = 1'b0;
  logic run_set = 1'b0, run_clr = 1'b0, trig = 1'b0;
  logic conv_start, conv_done = 1'b0;
  logic [CW-1:0] conv_chan, rd_chan = '0, last_chan;
  logic [DW-1:0] conv_data = '0, rd_data;
  logic rd_stb = 1'b0, rd_done, rd_ovr, glb_done, busy, run, irq;
  logic [NCH-1:0] ch_done, ch_overrun;

  int checks = 0, fails = 0;
  int nlog = 0;
  int clog [64];
  logic [DW-1:0] mdata [NCH];
  int seqn = 0, ccnt = 0, pch = 0;
  bit pend = 1'b0, ended = 1'b0;

  always #2 clk = ~clk;

  adc_scan_seq #(.NCH(NCH), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .cfg_mask(cfg_mask), .cfg_trig_mode(cfg_trig_mode),
    .cfg_single(cfg_single), .cfg_irq_en(cfg_irq_en), .run_set(run_set),
    .run_clr(run_clr), .trig(trig), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data), .rd_stb(rd_stb), .rd_chan(rd_chan),
    .rd_data(rd_data), .rd_done(rd_done), .rd_ovr(rd_ovr), .ch_done(ch_done),
    .ch_overrun(ch_overrun), .glb_done(glb_done), .last_chan(last_chan),
    .busy(busy), .run(run), .irq(irq)
  );

  // Converter core model: completion LAT falling edges after the start.
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (rst) begin
      pend = 1'b0;
    end else if (conv_start) begin
      if (nlog < 64) clog[nlog] = int'(conv_chan);
      nlog++;
      pch  = int'(conv_chan);
      seqn++;
      mdata[pch] = {conv_chan, 9'(seqn)};
      ccnt = LAT;
      pend = 1'b1;
    end else if (pend) begin
      if (ccnt == 1) begin
        conv_done = 1'b1;
        conv_data = mdata[pch];
        pend = 1'b0;
      end else begin
        ccnt--;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic do_run_set();
    run_set = 1'b1; step(1); run_set = 1'b0;
  endtask

  task automatic do_run_clr();
    run_clr = 1'b1; step(1); run_clr = 1'b0;
  endtask

  task automatic do_trig();
    trig = 1'b1; step(1); trig = 1'b0;
  endtask

  task automatic do_read(input int ch);
    rd_stb = 1'b1; rd_chan = CW'(ch); step(1); rd_stb = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    while ((busy || (run && !cfg_trig_mode && cfg_single)) && t < 2000) begin
      step(1);
      t++;
    end
    chk(t < 2000, req, t, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      chk(1'b0, "watchdog", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    // R3 reset state
    chk(ch_done == 0, "R3 reset done", int'(ch_done), 0);
    chk(ch_overrun == 0, "R3 reset overrun", int'(ch_overrun), 0);
    chk({busy, run, irq, glb_done} == 4'b0, "R10 reset status",
        int'({busy, run, irq, glb_done}), 0);

    // R1 R8: single-pass table
    for (int v = 0; v < 4; v++) begin
      logic [7:0] m;
      int exp_n, k;
      m = VEC[v][11:4];
      exp_n = int'(VEC[v][3:0]);
      cfg_mask = m; cfg_single = 1'b1; cfg_trig_mode = 1'b0;
      nlog = 0;
      do_run_set();
      wait_idle("R8 pass ends");
      step(10);
      chk(run == 1'b0, "R8 run dropped", int'(run), 0);
      chk(nlog == exp_n, "R8 one pass count", nlog, exp_n);
      k = 0;
      for (int c = 0; c < NCH; c++) begin
        if (m[c]) begin
          if (k < nlog) chk(clog[k] == c, "R1 ascending order", clog[k], c);
          k++;
        end
      end
      chk(ch_done == m, "R3 done flags", int'(ch_done), int'(m));
      chk(ch_overrun == 0, "R8 no overrun", int'(ch_overrun), 0);
      for (int c = 0; c < NCH; c++) begin
        if (m[c]) begin
          do_read(c);
          chk(rd_data == mdata[c], "R3 read data", int'(rd_data), int'(mdata[c]));
          chk(rd_done == 1'b1, "R3 read done", int'(rd_done), 1);
        end
      end
      chk(ch_done == 0, "R3 read clears", int'(ch_done), 0);
    end

    // R2 R4 R6: free scan on channels 1 and 2, stop during third conversion
    cfg_mask = 8'h06; cfg_single = 1'b0; nlog = 0;
    do_run_set();
    for (int t = 0; t < 200 && nlog < 3; t++) step(1);
    do_run_clr();
    chk(busy == 1'b1, "R6 in flight kept", int'(busy), 1);
    chk(run == 1'b0, "R6 run cleared", int'(run), 0);
    wait_idle("R6 completes");
    step(10);
    chk(nlog == 3, "R6 no further start", nlog, 3);
    chk(clog[0] == 1 && clog[1] == 2, "R1 free order", clog[1], 2);
    chk(clog[2] == 1, "R2 wrap to lowest", clog[2], 1);
    chk(ch_done == 8'h06, "R6 result written", int'(ch_done), 6);
    chk(ch_overrun == 8'h02, "R4 overrun set", int'(ch_overrun), 2);
    chk(glb_done == 1'b1 && last_chan == 3'd1, "R10 last channel", int'(last_chan), 1);
    // R5 enables gate the interrupt
    chk(irq == 1'b0, "R5 masked irq", int'(irq), 0);
    cfg_irq_en = 8'h04;
    step(2);
    chk(irq == 1'b1, "R5 irq raised", int'(irq), 1);
    do_read(1);
    chk(rd_ovr == 1'b1 && rd_done == 1'b1, "R4 read overrun", int'(rd_ovr), 1);
    chk(rd_data == mdata[1], "R3 newest data", int'(rd_data), int'(mdata[1]));
    chk(ch_overrun == 0, "R3 overrun cleared", int'(ch_overrun), 0);
    chk(glb_done == 1'b0, "R10 global cleared", int'(glb_done), 0);
    do_read(2);
    step(1);
    chk(irq == 1'b0, "R5 irq cleared", int'(irq), 0);
    cfg_irq_en = 8'h00;

    // R9: empty mask
    cfg_mask = 8'h00; nlog = 0;
    do_run_set();
    chk(run == 1'b0, "R9 run ignored", int'(run), 0);
    do_trig();
    step(20);
    chk(nlog == 0 && busy == 1'b0, "R9 no start", nlog, 0);

    // R7: triggered mode on channels 3 and 5
    cfg_mask = 8'h28; cfg_trig_mode = 1'b1; nlog = 0;
    do_run_set();
    step(10);
    chk(nlog == 0, "R7 waits for trigger", nlog, 0);
    do_trig();
    step(1);
    chk(busy == 1'b1, "R10 busy in flight", int'(busy), 1);
    do_trig();
    wait_idle("R7 first done");
    step(10);
    chk(nlog == 1 && clog[0] == 3, "R7 one per trigger", nlog, 1);
    chk(busy == 1'b0, "R10 busy low", int'(busy), 0);
    do_trig();
    step(1);
    wait_idle("R7 second done");
    do_trig();
    step(1);
    wait_idle("R7 third done");
    step(5);
    chk(nlog == 3, "R7 three triggers", nlog, 3);
    chk(clog[1] == 5, "R7 next channel", clog[1], 5);
    chk(clog[2] == 3, "R7 wrap", clog[2], 3);
    do_run_clr();
    cfg_trig_mode = 1'b0;
    do_read(3);
    do_read(5);

    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule